// File: doc/BRIEF.md
# Pad Connectivity NAND-Tree Test Controller

This block is a manufacturing test-mode wrapper placed between a chip's core logic and its pad ring. It decides, for every output-only pad and every bidirectional pad, what value goes to the pad cell and whether that pad's driver is enabled. A 2-bit mode select picks one of four behaviours. In functional mode the core's values and enables pass straight through. In float mode every pad driver is switched off, which lets test equipment isolate the die. The two NAND-tree modes chain an ordered set of pad inputs through a combinational NAND cascade and copy the single chain result onto a group of observation pads, so a tester can check each pad's connection by applying static patterns.

In input-tree mode the chain runs over the twelve dedicated input pads, and every bidirectional pad is driven with the result. In I/O-tree mode every bidirectional pad becomes an input and joins the chain, and all output-only pads show the result. The oscillator output pad has no enable and follows the core's oscillator signal in every mode. The block has no clock and no stored state. The control pins are static levels, so there is no streaming handshake and no back-pressure.

Top module: `padtest_ctrl`

## Requirements
- R1: With test_mode = 2'b00 (functional), pad_out, pad_out_oe, pad_bidi_out and pad_bidi_oe equal core_out, core_out_oe, core_bidi_out and core_bidi_oe bit for bit.
- R2: With test_mode = 2'b01 (float), every bit of pad_out_oe and pad_bidi_oe is 0.
- R3: pad_osc equals core_osc in all four modes.
- R4: In input-tree mode (test_mode = 2'b10), the chain takes ded_in with bit 0 as the first chain position and bit 11 as the last. The bit meanings are: 0 bus-power good, 1 VBUS-powered, 2 drive-power good, 3 disk ready, 4 system interrupt, 5 DMA request, 6 I/O ready, 7 cartridge detect, 8 eject, 9 reset, 10 interface mode, 11 ATA enable.
- R5: In input-tree mode, every bit of pad_bidi_oe is 1 and every bit of pad_bidi_out carries the chain result. pad_out and pad_out_oe follow the core in this mode.
- R6: In I/O-tree mode (test_mode = 2'b11), every bit of pad_bidi_oe is 0. The bidirectional vector is laid out as bits 0..9 general-purpose lines 0..9, bits 10..25 data lines 0..15, and bit 26 serial data. The chain order is: general-purpose lines 0 to 9; then data lines 15, 0, 14, 1, 13, 2, 12, 3, 11, 4, 10, 5, 9, 6, 8, 7; then serial data last.
- R7: In I/O-tree mode, every bit of pad_out_oe is 1 and every bit of pad_out carries the chain result. The output-only bits are: 0..1 LEDs, 2 high-power enable, 3 drive reset, 4 write strobe, 5 read strobe, 6 DMA acknowledge, 7 pull-up enable, 8 pull-down enable, 9..10 chip selects, 11..13 address, 14 serial clock.
- R8: With every chain input at 1, the chain result is 1.
- R9: Taking only the first chain input to 0 makes the result 0, and restoring it gives 1 again.
- R10: Let p be the highest chain position holding a 0. If p is 0, the result is 0. If p is 1 or more, the result is 1 when p is even and 0 when p is odd. So clearing positions 1, 2, 3 and onward, one at a time and cumulatively, flips the result at every step.
- R11: In the three test modes, core_out_oe and core_bidi_oe have no effect on the pad enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_mode | input | 2 | 00 functional, 01 float, 10 input tree, 11 I/O tree |
| core_osc | input | 1 | Core oscillator drive |
| pad_osc | output | 1 | Oscillator pad output, always driven |
| ded_in | input | 12 | Dedicated input pad values, chain order per R4 |
| core_out | input | 15 | Core values for output-only pads |
| core_out_oe | input | 15 | Core enables for output-only pads |
| pad_out | output | 15 | Values to output-only pad cells |
| pad_out_oe | output | 15 | Enables to output-only pad cells |
| core_bidi_out | input | 27 | Core values for bidirectional pads |
| core_bidi_oe | input | 27 | Core enables for bidirectional pads |
| bidi_in | input | 27 | Receive values from bidirectional pads, layout per R6 |
| pad_bidi_out | output | 27 | Values to bidirectional pad cells |
| pad_bidi_oe | output | 27 | Enables to bidirectional pad cells |

## Verification
The bench builds the block with its default widths: 12 dedicated inputs, 10 general-purpose lines, 16 data lines and 15 output-only pads. With only 12 dedicated inputs, every one of the 4096 input-tree patterns is swept, and each result is compared with the highest-zero rule. The 27-input I/O chain is too wide to sweep, so it is covered by the cumulative clearing walk in chain order plus a few thousand pseudo-random patterns. Any misplaced data line in the interleave then shows up as a mismatch.

// File: rtl/padtest_pkg.sv
package padtest_pkg;
  typedef enum logic [1:0] {
    MODE_FUNC    = 2'b00,
    MODE_FLOAT   = 2'b01,
    MODE_IN_TREE = 2'b10,
    MODE_IO_TREE = 2'b11
  } test_mode_e;
endpackage

// File: rtl/nand_chain.sv
module nand_chain #(
  parameter int W = 12
) (
  input  logic [W-1:0] chain_in,
  output logic         chain_out
);
  // Output polarity fixed so an all-ones chain reads 1.
  localparam logic FLIP = ((W - 1) % 2) == 1;

  logic [W-1:0] stg;
  assign stg[0] = chain_in[0];

  genvar k;
  generate
    for (k = 1; k < W; k++) begin : g_stage
      assign stg[k] = ~(stg[k-1] & chain_in[k]);
    end
  endgenerate

  assign chain_out = stg[W-1] ^ FLIP;

  always_comb begin
    if (!$isunknown(chain_in)) begin
      // R8
      all_ones_high_chk: assert (!(&chain_in) || chain_out)
        else $error("all-ones chain did not give 1");
    end
  end
endmodule

// File: rtl/io_chain_order.sv
module io_chain_order #(
  parameter int N_GPIO = 10,
  parameter int N_DATA = 16,
  localparam int N_BIDI = N_GPIO + N_DATA + 1
) (
  input  logic [N_BIDI-1:0] bidi_in,
  output logic [N_BIDI-1:0] chain_vec
);
  genvar g, j;
  generate
    for (g = 0; g < N_GPIO; g++) begin : g_gpio
      assign chain_vec[g] = bidi_in[g];
    end
    for (j = 0; j < N_DATA; j++) begin : g_data
      // even slots walk down from the top line, odd slots up from line 0
      localparam int SRC = (j % 2 == 0) ? (N_DATA - 1 - j / 2) : (j / 2);
      assign chain_vec[N_GPIO + j] = bidi_in[N_GPIO + SRC];
    end
  endgenerate

  assign chain_vec[N_BIDI-1] = bidi_in[N_BIDI-1];
endmodule

// File: rtl/pad_mode_mux.sv
module pad_mode_mux
  import padtest_pkg::*;
#(
  parameter int N_OUT  = 15,
  parameter int N_BIDI = 27
) (
  input  test_mode_e        mode,
  input  logic [N_OUT-1:0]  core_out,
  input  logic [N_OUT-1:0]  core_out_oe,
  input  logic [N_BIDI-1:0] core_bidi_out,
  input  logic [N_BIDI-1:0] core_bidi_oe,
  input  logic              in_tree_res,
  input  logic              io_tree_res,
  output logic [N_OUT-1:0]  pad_out,
  output logic [N_OUT-1:0]  pad_out_oe,
  output logic [N_BIDI-1:0] pad_bidi_out,
  output logic [N_BIDI-1:0] pad_bidi_oe
);
  always_comb begin
    pad_out      = core_out;
    pad_out_oe   = core_out_oe;
    pad_bidi_out = core_bidi_out;
    pad_bidi_oe  = core_bidi_oe;
    unique case (mode)
      MODE_FUNC: ;
      MODE_FLOAT: begin
        pad_out_oe  = '0;
        pad_bidi_oe = '0;
      end
      MODE_IN_TREE: begin
        pad_bidi_oe  = '1;
        pad_bidi_out = {N_BIDI{in_tree_res}};
      end
      MODE_IO_TREE: begin
        pad_bidi_oe = '0;
        pad_out_oe  = '1;
        pad_out     = {N_OUT{io_tree_res}};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/padtest_ctrl.sv
module padtest_ctrl
  import padtest_pkg::*;
#(
  parameter int N_DIN  = 12,
  parameter int N_GPIO = 10,
  parameter int N_DATA = 16,
  parameter int N_OUT  = 15,
  localparam int N_BIDI = N_GPIO + N_DATA + 1
) (
  input  logic [1:0]        test_mode,
  input  logic              core_osc,
  output logic              pad_osc,
  input  logic [N_DIN-1:0]  ded_in,
  input  logic [N_OUT-1:0]  core_out,
  input  logic [N_OUT-1:0]  core_out_oe,
  output logic [N_OUT-1:0]  pad_out,
  output logic [N_OUT-1:0]  pad_out_oe,
  input  logic [N_BIDI-1:0] core_bidi_out,
  input  logic [N_BIDI-1:0] core_bidi_oe,
  input  logic [N_BIDI-1:0] bidi_in,
  output logic [N_BIDI-1:0] pad_bidi_out,
  output logic [N_BIDI-1:0] pad_bidi_oe
);
  test_mode_e        mode;
  logic              in_res, io_res;
  logic [N_BIDI-1:0] io_vec;

  assign mode    = test_mode_e'(test_mode);
  assign pad_osc = core_osc;  // oscillator driver has no enable

  nand_chain #(.W(N_DIN)) i_in_chain (
    .chain_in (ded_in),
    .chain_out(in_res)
  );

  io_chain_order #(.N_GPIO(N_GPIO), .N_DATA(N_DATA)) i_io_order (
    .bidi_in  (bidi_in),
    .chain_vec(io_vec)
  );

  nand_chain #(.W(N_BIDI)) i_io_chain (
    .chain_in (io_vec),
    .chain_out(io_res)
  );

  pad_mode_mux #(.N_OUT(N_OUT), .N_BIDI(N_BIDI)) i_mux (
    .mode         (mode),
    .core_out     (core_out),
    .core_out_oe  (core_out_oe),
    .core_bidi_out(core_bidi_out),
    .core_bidi_oe (core_bidi_oe),
    .in_tree_res  (in_res),
    .io_tree_res  (io_res),
    .pad_out      (pad_out),
    .pad_out_oe   (pad_out_oe),
    .pad_bidi_out (pad_bidi_out),
    .pad_bidi_oe  (pad_bidi_oe)
  );

  always_comb begin
    if (!$isunknown(test_mode)) begin
      // R1
      func_pass_chk: assert (test_mode != 2'b00 ||
        (pad_out == core_out && pad_out_oe == core_out_oe &&
         pad_bidi_out == core_bidi_out && pad_bidi_oe == core_bidi_oe))
        else $error("functional mode altered core signals");
      // R2
      float_all_off_chk: assert (test_mode != 2'b01 ||
        (pad_out_oe == '0 && pad_bidi_oe == '0))
        else $error("float mode left a driver on");
      // R5
      in_tree_drive_chk: assert (test_mode != 2'b10 ||
        ((&pad_bidi_oe) && (pad_bidi_out == '0 || (&pad_bidi_out))))
        else $error("input tree observation pads inconsistent");
      // R7
      io_tree_obs_chk: assert (test_mode != 2'b11 ||
        ((&pad_out_oe) && pad_bidi_oe == '0 &&
         (pad_out == '0 || (&pad_out))))
        else $error("io tree observation pads inconsistent");
    end
  end
endmodule

// File: tb/test_padtest_ctrl.sv
module test_padtest_ctrl;
  localparam int ND = 12;
  localparam int NO = 15;
  localparam int NB = 27;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [1:0]    test_mode;
  logic          core_osc, pad_osc;
  logic [ND-1:0] ded_in;
  logic [NO-1:0] core_out, core_out_oe, pad_out, pad_out_oe;
  logic [NB-1:0] core_bidi_out, core_bidi_oe, bidi_in, pad_bidi_out, pad_bidi_oe;

  int checks = 0;
  int errors = 0;

  padtest_ctrl i_padtest_ctrl (
    .test_mode(test_mode), .core_osc(core_osc), .pad_osc(pad_osc),
    .ded_in(ded_in), .core_out(core_out), .core_out_oe(core_out_oe),
    .pad_out(pad_out), .pad_out_oe(pad_out_oe),
    .core_bidi_out(core_bidi_out), .core_bidi_oe(core_bidi_oe),
    .bidi_in(bidi_in), .pad_bidi_out(pad_bidi_out), .pad_bidi_oe(pad_bidi_oe)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // highest-zero rule from R8/R9/R10
  function automatic logic exp_tree(input logic [63:0] v, input int w);
    int p = -1;
    for (int i = 0; i < w; i++) if (!v[i]) p = i;
    if (p < 0) return 1'b1;
    if (p == 0) return 1'b0;
    return (p % 2) == 0;
  endfunction

  // chain position -> bidirectional vector bit (R6)
  function automatic int io_pad(input int k);
    int j;
    if (k < 10) return k;
    if (k < 26) begin
      j = k - 10;
      return 10 + ((j % 2 == 0) ? (15 - j / 2) : (j / 2));
    end
    return 26;
  endfunction

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic check_in_tree(input string req);
    logic e;
    e = exp_tree(64'(ded_in), ND);
    chk(pad_bidi_out == {NB{e}} && (&pad_bidi_oe), req,
        64'(pad_bidi_out), 64'({NB{e}}));
  endtask

  task automatic check_io_tree(input string req);
    logic [NB-1:0] cv;
    logic e;
    for (int k = 0; k < NB; k++) cv[k] = bidi_in[io_pad(k)];
    e = exp_tree(64'(cv), NB);
    chk(pad_out == {NO{e}} && (&pad_out_oe) && pad_bidi_oe == '0, req,
        64'(pad_out), 64'({NO{e}}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_mode = 2'b00; core_osc = 0; ded_in = '1; bidi_in = '1;
    core_out = '0; core_out_oe = '0; core_bidi_out = '0; core_bidi_oe = '0;
    settle();
    chk(pad_out_oe == '0 && pad_bidi_oe == '0, "R1 initial", 64'(pad_bidi_oe), 0);

    // R1 functional pass-through
    for (int n = 0; n < 20; n++) begin
      core_out = NO'($urandom); core_out_oe = NO'($urandom);
      core_bidi_out = NB'($urandom); core_bidi_oe = NB'($urandom);
      settle();
      chk(pad_out == core_out && pad_out_oe == core_out_oe &&
          pad_bidi_out == core_bidi_out && pad_bidi_oe == core_bidi_oe,
          "R1", 64'(pad_bidi_out), 64'(core_bidi_out));
    end

    // R3 oscillator in every mode, R2/R11 float mode
    for (int m = 0; m < 4; m++) begin
      test_mode = 2'(m);
      core_osc = 1'b1; settle();
      chk(pad_osc == 1'b1, "R3", 64'(pad_osc), 1);
      core_osc = 1'b0; settle();
      chk(pad_osc == 1'b0, "R3", 64'(pad_osc), 0);
    end
    test_mode = 2'b01; core_out_oe = '1; core_bidi_oe = '1; settle();
    chk(pad_out_oe == '0 && pad_bidi_oe == '0, "R2 R11 float",
        64'(pad_out_oe), 0);

    // input tree: R4 R5 R8 R9 R10 R11
    test_mode = 2'b10; core_bidi_oe = '0;
    core_out = NO'(15'h2A5C); core_out_oe = NO'(15'h1337);
    ded_in = '1; settle();
    chk(pad_bidi_out == '1, "R8 input tree", 64'(pad_bidi_out), 64'({NB{1'b1}}));
    chk(&pad_bidi_oe, "R5 R11 bidi driven", 64'(pad_bidi_oe), 64'({NB{1'b1}}));
    chk(pad_out == core_out && pad_out_oe == core_out_oe, "R5 outputs follow core",
        64'(pad_out), 64'(core_out));
    ded_in[0] = 1'b0; settle();
    chk(pad_bidi_out == '0, "R9 first low", 64'(pad_bidi_out), 0);
    ded_in[0] = 1'b1; settle();
    chk(pad_bidi_out == '1, "R9 restore", 64'(pad_bidi_out), 64'({NB{1'b1}}));
    for (int k = 1; k < ND; k++) begin
      ded_in[k] = 1'b0; settle();
      check_in_tree("R10 R4 in-tree walk");
    end
    for (int v = 0; v < (1 << ND); v++) begin
      ded_in = ND'(v); settle();
      check_in_tree("R4 R10 in-tree sweep");
    end

    // I/O tree: R6 R7 R8 R9 R10 R11
    test_mode = 2'b11; core_bidi_oe = '1; core_out_oe = '0; bidi_in = '1; settle();
    chk(pad_out == '1, "R8 io tree", 64'(pad_out), 64'({NO{1'b1}}));
    check_io_tree("R6 R7 R11 io all ones");
    bidi_in[io_pad(0)] = 1'b0; settle();
    chk(pad_out == '0, "R9 io first low", 64'(pad_out), 0);
    bidi_in[io_pad(0)] = 1'b1; settle();
    chk(pad_out == '1, "R9 io restore", 64'(pad_out), 64'({NO{1'b1}}));
    for (int k = 1; k < NB; k++) begin
      bidi_in[io_pad(k)] = 1'b0; settle();
      check_io_tree("R10 R6 io walk");
    end
    for (int n = 0; n < 3000; n++) begin
      bidi_in = NB'($urandom);
      if (n % 3 == 0) bidi_in = bidi_in | NB'($urandom);
      if (n % 5 == 0) bidi_in = '1 & ~(NB'(1) << ($urandom % NB));
      settle();
      check_io_tree("R6 R7 io random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule